// File: doc/BRIEF.md
# Receive Chunk Checksum Checker

This block sits on the receive byte path of an octal double-data-rate serial flash controller while a read is in progress. Read data from the flash is split into chunks whose length comes from a small code. Each chunk is followed by two checksum bytes from the flash. The block forwards the payload bytes, folds each one into a running XOR, and removes the two checksum bytes from the payload stream. It then compares both bytes with the folded value.

Every completed checksum pair latches the received bytes into two fields that software can read. It also sets a "new checksum" status bit, and it sets an error status bit when the pair does not match. A separate active-low ECC failure line from the flash is synchronized, and its falling edge sets a third status bit. Each status bit is sticky and is cleared by a one-cycle clear pulse. Each bit drives its own interrupt line through a per-source enable.

Top module: `rx_chunk_csum_chk`

## Requirements
- R1: After reset, `irq_status`, `irq_o`, `csum_lo`, `csum_hi` and `pay_valid` are all zero.
- R2: After `phase_start` or after a checksum pair, the next chunk-length accepted bytes are forwarded: `pay_valid` is high with `pay_byte` equal to `rx_byte` in the same cycle. The two bytes that follow are not forwarded.
- R3: Status bit 0 (checksum error) is set one cycle after the second checksum byte when the first checksum byte or the second checksum byte differs from the XOR of the chunk's payload bytes. It is left unchanged when both bytes equal that XOR.
- R4: One cycle after the second checksum byte, `csum_lo` holds the first checksum byte, `csum_hi` holds the second, and status bit 1 (new checksum) is set, whether or not the pair matched. Between pairs, both fields hold their values.
- R5: `phase_start` clears the XOR, the byte count and the chunk position. A byte offered in the same cycle as `phase_start` is dropped and is not forwarded.
- R6: Each status bit stays set until a clear pulse on its bit of `irq_clr`. The clear takes effect on the next edge. If a set event and a clear arrive in the same cycle, the set wins.
- R7: `irq_o[k]` is high exactly when status bit k and `irq_en[k]` are both high.
- R8: A falling edge of `ecc_fail_n` passes through a two-flop synchronizer and sets status bit 2 three rising edges after the change. If the input stays low, the bit is not set again after it has been cleared. Only a new high-to-low transition sets it again.
- R9: Chunk code c gives 2^(c+1) payload bytes: code 0 gives 2 bytes and code 7 gives 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_start | input | 1 | Pulse at the start of a read data phase |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | 8 | Received byte |
| chunk_code | input | CODE_W | Chunk size code, held stable during a phase |
| ecc_fail_n | input | 1 | Asynchronous active-low ECC failure from the flash |
| irq_en | input | 3 | Per-source interrupt enable (bit 0 error, bit 1 new checksum, bit 2 ECC) |
| irq_clr | input | 3 | Write-one-to-clear pulses for the status bits |
| pay_valid | output | 1 | Payload byte forwarded this cycle |
| pay_byte | output | 8 | Forwarded payload byte |
| csum_lo | output | 8 | Last received first checksum byte |
| csum_hi | output | 8 | Last received second checksum byte |
| irq_status | output | 3 | Sticky status bits |
| irq_o | output | 3 | Enabled interrupt lines |

## Verification
Random payloads over chunk codes 0 to 3 are each closed with one of three pairs: a matching pair, a pair with a wrong first byte, or a pair with a wrong second byte. These cases separate a comparator that checks both bytes from one that checks only one byte, and they show that the new-checksum bit is set regardless of the match result. A 256-byte chunk and a 2-byte chunk check both ends of the code-to-length mapping. A `phase_start` in the middle of a chunk, followed by a matching chunk, shows whether the XOR and the count restart. A clear that lands on a set event shows which of the two wins. For the ECC line, a fall, a long low stretch with a clear inside it, and a second fall separate edge detection from level detection.

// File: rtl/csum_pkg.sv
package csum_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_IRQ = 3;
  localparam int IRQ_ERR = 0;
  localparam int IRQ_VLD = 1;
  localparam int IRQ_ECC = 2;

  typedef enum logic [1:0] {
    POS_PAYLOAD = 2'd0,
    POS_SUM_A   = 2'd1,
    POS_SUM_B   = 2'd2
  } chunk_pos_t;

  // payload length of a chunk for a given size code
  function automatic int unsigned chunk_len(input int unsigned code);
    return 32'd2 << code;
  endfunction

  // fold one byte into the running checksum
  function automatic logic [BYTE_W-1:0] fold_byte(input logic [BYTE_W-1:0] acc,
                                                  input logic [BYTE_W-1:0] b);
    return acc ^ b;
  endfunction

  // a returned pair is bad when either byte differs from the folded value
  function automatic logic pair_bad(input logic [BYTE_W-1:0] folded,
                                    input logic [BYTE_W-1:0] first,
                                    input logic [BYTE_W-1:0] second);
    return (first != folded) || (second != folded);
  endfunction
endpackage

// File: rtl/csum_framer.sv
module csum_framer
  import csum_pkg::*;
#(
  parameter int CODE_W = 3,
  localparam int CNT_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_start,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [CODE_W-1:0] chunk_code,
  output logic              ev_pay,
  output logic              ev_pair,
  output logic              ev_mismatch,
  output logic [BYTE_W-1:0] pair_first,
  output logic [BYTE_W-1:0] pair_second
);
  chunk_pos_t        pos_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_last;
  logic [BYTE_W-1:0] acc_q;
  logic [BYTE_W-1:0] first_q;
  logic              take;
  logic              ev_first;

  assign cnt_last    = CNT_W'(chunk_len(32'(chunk_code)) - 32'd1);
  assign take        = rx_valid && !phase_start;
  assign ev_pay      = take && (pos_q == POS_PAYLOAD);
  assign ev_first    = take && (pos_q == POS_SUM_A);
  assign ev_pair     = take && (pos_q == POS_SUM_B);
  assign ev_mismatch = ev_pair && pair_bad(acc_q, first_q, rx_byte);
  assign pair_first  = first_q;
  assign pair_second = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= POS_PAYLOAD;
      cnt_q   <= '0;
      acc_q   <= '0;
      first_q <= '0;
    end else if (phase_start) begin
      pos_q <= POS_PAYLOAD;
      cnt_q <= '0;
      acc_q <= '0;
    end else if (ev_pay) begin
      acc_q <= fold_byte(acc_q, rx_byte);
      if (cnt_q == cnt_last) begin
        cnt_q <= '0;
        pos_q <= POS_SUM_A;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (ev_first) begin
      first_q <= rx_byte;
      pos_q   <= POS_SUM_B;
    end else if (ev_pair) begin
      acc_q <= '0;
      cnt_q <= '0;
      pos_q <= POS_PAYLOAD;
    end
  end
endmodule

// File: rtl/csum_sticky_bit.sv
module csum_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic en,
  output logic status,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= 1'b0;
    else if (set_ev) status <= 1'b1;
    else if (clr_ev) status <= 1'b0;
  end

  assign irq = status && en;
endmodule

// File: rtl/ecc_fall_det.sv
module ecc_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q && !sync_q[STAGES-1];
endmodule

// File: rtl/rx_chunk_csum_chk.sv
module rx_chunk_csum_chk
  import csum_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_start,
  input  logic               rx_valid,
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic [CODE_W-1:0]  chunk_code,
  input  logic               ecc_fail_n,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_clr,
  output logic               pay_valid,
  output logic [BYTE_W-1:0]  pay_byte,
  output logic [BYTE_W-1:0]  csum_lo,
  output logic [BYTE_W-1:0]  csum_hi,
  output logic [NUM_IRQ-1:0] irq_status,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic              ev_pay;
  logic              ev_pair;
  logic              ev_mismatch;
  logic              ev_ecc_fall;
  logic [BYTE_W-1:0] pair_first;
  logic [BYTE_W-1:0] pair_second;
  logic [NUM_IRQ-1:0] set_vec;

  csum_framer #(.CODE_W(CODE_W)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_start (phase_start),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .chunk_code  (chunk_code),
    .ev_pay      (ev_pay),
    .ev_pair     (ev_pair),
    .ev_mismatch (ev_mismatch),
    .pair_first  (pair_first),
    .pair_second (pair_second)
  );

  ecc_fall_det #(.STAGES(SYNC_STAGES)) u_ecc (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_n (ecc_fail_n),
    .fall   (ev_ecc_fall)
  );

  assign pay_valid = ev_pay;
  assign pay_byte  = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csum_lo <= '0;
      csum_hi <= '0;
    end else if (ev_pair) begin
      csum_lo <= pair_first;
      csum_hi <= pair_second;
    end
  end

  always_comb begin
    set_vec          = '0;
    set_vec[IRQ_ERR] = ev_mismatch;
    set_vec[IRQ_VLD] = ev_pair;
    set_vec[IRQ_ECC] = ev_ecc_fall;
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    csum_sticky_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (set_vec[k]),
      .clr_ev (irq_clr[k]),
      .en     (irq_en[k]),
      .status (irq_status[k]),
      .irq    (irq_o[k])
    );
  end
endmodule

// File: rtl/rx_chunk_csum_chk_sva.sv
module rx_chunk_csum_chk_sva
  import csum_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               phase_start,
  input logic               rx_valid,
  input logic               pay_valid,
  input logic               ev_pair,
  input logic               ev_mismatch,
  input logic               ev_ecc_fall,
  input logic [NUM_IRQ-1:0] irq_status,
  input logic [NUM_IRQ-1:0] irq_clr,
  input logic [BYTE_W-1:0]  csum_lo,
  input logic [BYTE_W-1:0]  csum_hi
);
  a_r2_pass_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> (rx_valid && !phase_start));

  a_r3_error_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |=> irq_status[IRQ_ERR]);

  a_r4_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair |=> irq_status[IRQ_VLD]);

  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_pair |=> $stable({csum_hi, csum_lo}));

  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[IRQ_ERR] && !irq_clr[IRQ_ERR]) |=> irq_status[IRQ_ERR]);

  a_r8_ecc_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ecc_fall |=> irq_status[IRQ_ECC]);

  a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ecc_fall |=> !ev_ecc_fall);
endmodule

bind rx_chunk_csum_chk rx_chunk_csum_chk_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase_start (phase_start),
  .rx_valid    (rx_valid),
  .pay_valid   (pay_valid),
  .ev_pair     (ev_pair),
  .ev_mismatch (ev_mismatch),
  .ev_ecc_fall (ev_ecc_fall),
  .irq_status  (irq_status),
  .irq_clr     (irq_clr),
  .csum_lo     (csum_lo),
  .csum_hi     (csum_hi)
);

// File: tb/rx_chunk_csum_chk_tb.sv
module rx_chunk_csum_chk_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_start = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [2:0] chunk_code = '0;
  logic       ecc_fail_n = 1'b1;
  logic [2:0] irq_en = '0;
  logic [2:0] irq_clr = '0;
  logic       pay_valid;
  logic [7:0] pay_byte;
  logic [7:0] csum_lo;
  logic [7:0] csum_hi;
  logic [2:0] irq_status;
  logic [2:0] irq_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // bench model of the chunk position
  int         m_pos = 0;
  int         m_cnt = 0;
  logic [7:0] m_acc = '0;
  logic [7:0] m_first = '0;
  bit         m_err = 0;
  int         n_pay = 0;

  rx_chunk_csum_chk u_dut (
    .clk(clk), .rst_n(rst_n), .phase_start(phase_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .chunk_code(chunk_code), .ecc_fail_n(ecc_fail_n),
    .irq_en(irq_en), .irq_clr(irq_clr), .pay_valid(pay_valid), .pay_byte(pay_byte),
    .csum_lo(csum_lo), .csum_hi(csum_hi), .irq_status(irq_status), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int exp_len(input int code);
    int n = 1;
    for (int i = 0; i <= code; i++) n = n * 2;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic [2:0] clr);
    bit pv;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    irq_clr  = clr;
    #1;
    pv = (m_pos == 0);
    chk(pay_valid == pv, "R2 pay_valid", pay_valid, pv);
    if (pv) begin
      chk(pay_byte == b, "R2 pay_byte", pay_byte, b);
      n_pay++;
    end
    if (m_pos == 0) begin
      m_acc ^= b;
      m_cnt++;
      if (m_cnt == exp_len(chunk_code)) begin
        m_cnt = 0;
        m_pos = 1;
      end
    end else if (m_pos == 1) begin
      m_first = b;
      m_pos = 2;
    end else begin
      m_err = (m_first != m_acc) || (b != m_acc);
      m_acc = '0;
      m_pos = 0;
    end
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
    irq_clr  = '0;
  endtask

  task automatic clear_status(input logic [2:0] mask);
    @(negedge clk);
    irq_clr = mask;
    @(posedge clk);
    #1 irq_clr = '0;
    @(negedge clk);
    chk((irq_status & mask) == 3'b000, "R6 clear", irq_status, 0);
  endtask

  // mode 0 good pair, 1 bad first byte, 2 bad second byte
  task automatic run_chunk(input int code, input int mode);
    logic [7:0] a, b, nz;
    int len;
    chunk_code = 3'(code);
    len = exp_len(code);
    n_pay = 0;
    for (int i = 0; i < len; i++) push(8'($urandom), 3'b000);
    chk(n_pay == len, "R9 chunk length", n_pay, len);
    nz = 8'($urandom_range(1, 255));
    a = m_acc;
    b = m_acc;
    if (mode == 1) a ^= nz;
    if (mode == 2) b ^= nz;
    push(a, 3'b000);
    push(b, 3'b000);
    irq_en = 3'($urandom);
    @(negedge clk);
    chk(csum_lo == a, "R4 csum_lo", csum_lo, a);
    chk(csum_hi == b, "R4 csum_hi", csum_hi, b);
    chk(irq_status[1] == 1'b1, "R4 new checksum bit", irq_status[1], 1);
    chk(irq_status[0] == m_err, "R3 error bit", irq_status[0], m_err);
    chk(m_err == (mode != 0), "R3 model mode", m_err, mode != 0);
    chk(irq_o == (irq_status & irq_en), "R7 gating", irq_o, irq_status & irq_en);
    clear_status(3'b011);
  endtask

  initial begin
    void'($urandom(32'h0c5e_1d42));
    repeat (3) @(negedge clk);
    chk(irq_status == 0 && irq_o == 0, "R1 status reset", irq_status, 0);
    chk(csum_lo == 0 && csum_hi == 0, "R1 fields reset", {csum_hi, csum_lo}, 0);
    chk(pay_valid == 0, "R1 pay_valid reset", pay_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    phase_start = 1'b1;
    @(negedge clk);
    phase_start = 1'b0;

    // directed ends of the size code (R9)
    run_chunk(0, 0);
    run_chunk(7, 0);
    run_chunk(0, 2);

    // random mix
    for (int n = 0; n < 24; n++) run_chunk($urandom_range(0, 3), $urandom_range(0, 2));

    // R5: phase_start in mid chunk drops the byte and restarts the count
    chunk_code = 3'd1;
    push(8'h5a, 3'b000);
    push(8'h33, 3'b000);
    push(8'h81, 3'b000);
    @(negedge clk);
    phase_start = 1'b1;
    rx_valid = 1'b1;
    rx_byte = 8'hee;
    #1;
    chk(pay_valid == 1'b0, "R5 byte dropped", pay_valid, 0);
    @(posedge clk);
    #1;
    phase_start = 1'b0;
    rx_valid = 1'b0;
    m_pos = 0;
    m_cnt = 0;
    m_acc = '0;
    run_chunk(1, 0);

    // R6: set wins over a clear in the same cycle
    chunk_code = 3'd0;
    push(8'h11, 3'b000);
    push(8'h22, 3'b000);
    push(8'h33, 3'b000);
    push(8'h33, 3'b010);
    @(negedge clk);
    chk(irq_status[1] == 1'b1, "R6 set wins", irq_status[1], 1);
    chk(irq_status[0] == 1'b0, "R3 matched pair", irq_status[0], 0);
    clear_status(3'b011);

    // R8: ECC falling edge through the synchronizer
    irq_en = 3'b100;
    @(negedge clk);
    ecc_fail_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(irq_status[2] == 1'b0, "R8 not before third edge", irq_status[2], 0);
    @(posedge clk);
    @(negedge clk);
    chk(irq_status[2] == 1'b1, "R8 set on fall", irq_status[2], 1);
    chk(irq_o[2] == 1'b1, "R7 ecc irq enabled", irq_o[2], 1);
    clear_status(3'b100);
    repeat (10) @(negedge clk);
    chk(irq_status[2] == 1'b0, "R8 no repeat while low", irq_status[2], 0);
    ecc_fail_n = 1'b1;
    repeat (5) @(negedge clk);
    ecc_fail_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(irq_status[2] == 1'b1, "R8 new fall sets again", irq_status[2], 1);
    irq_en = 3'b000;
    #1;
    chk(irq_o == 3'b000, "R7 disabled", irq_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule